// File: doc/BRIEF.md
# Sixteen-bit ALU with status flags

A combinational arithmetic and logic unit for a small 16-bit RISC datapath. Each evaluation takes a source operand, a destination operand, the incoming carry, a 4-bit operation code and a byte/word select. It returns the result, the next values of the four status flags (overflow V, negative N, zero Z, carry C), a per-flag update mask and a result write-enable. The surrounding core uses the mask to decide which status bits it stores, and the write-enable to decide whether the result goes back to the destination.

Subtraction is formed as destination plus inverted source plus one (or plus the carry), so a carry of one after a subtraction means that no borrow occurred. A packed-BCD add with carry is also provided. Compare and bit test only produce flags. Bit clear, bit set and move leave every flag alone. In byte mode only bits 7:0 take part, and the upper result byte is zero.

Top module: `alu16`

## Requirements
- R1: Add (op 0x0) returns dst+src and add-with-carry (op 0x1) returns dst+src+carry_i. C is the carry out of the MSB, N is the result MSB and Z is set for a zero result.
- R2: For add, add-with-carry, subtract, subtract-with-carry and compare, V is set when the two adder inputs (dst and src for adds, dst and NOT src for subtracts) share a sign and the result sign differs from them.
- R3: Subtract (op 0x3) returns dst+NOT(src)+1 and subtract-with-carry (op 0x2) returns dst+NOT(src)+carry_i. C=1 means no borrow.
- R4: Compare (op 0x4) sets the same flags as subtract, with result_we_o=0. result_o carries the difference.
- R5: Decimal add (op 0x5) adds packed BCD operands plus carry_i, correcting each digit by 6 when its sum exceeds 9. C is set when the decimal sum exceeds 9999 (word) or 99 (byte). N and Z follow the result. flag_we_o is 4'b0111, so V is not written.
- R6: AND (op 0xA) and bit test (op 0x6) produce src AND dst, with N the MSB, Z for zero, C = NOT Z and V=0. Bit test has result_we_o=0.
- R7: XOR (op 0x9) produces src XOR dst, with N, Z and C as for AND, and V set when both operands are negative.
- R8: Bit clear (op 0x7, NOT src AND dst), bit set (op 0x8, src OR dst) and move (op 0xB, src) write the result with flag_we_o=0.
- R9: With byte_i=1, only bits 7:0 are used, all flags come from bit 7 and the 8-bit lane, and result_o[15:8] is zero.
- R10: Codes 0xC to 0xF are reserved. They return dst unchanged with result_we_o=0 and flag_we_o=0.
- R11: flag_we_o holds V at bit 3, N at bit 2, Z at bit 1 and C at bit 0. A flag output whose mask bit is 0 reads 0. result_we_o is 1 for ops 0x0-0x3, 0x5 and 0x7-0xB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| carry_i | input | 1 | Incoming carry flag |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 = byte operation, 0 = word operation |
| result_o | output | 16 | Operation result |
| flag_v_o | output | 1 | Next overflow flag |
| flag_n_o | output | 1 | Next negative flag |
| flag_z_o | output | 1 | Next zero flag |
| flag_c_o | output | 1 | Next carry flag |
| flag_we_o | output | 4 | Flag update mask {V,N,Z,C} |
| result_we_o | output | 1 | Result writeback enable |

## Verification
Every output is purely combinational, so each result, flag and mask is due in the same cycle in which the operands and code are applied, with no register on the path. The bench drives a new operation on the falling clock edge and samples all outputs one nanosecond later, well before the next rising edge. No check ever waits for a later cycle, and no value from an earlier stimulus can leak into one.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
   localparam logic [3:0] OP_ADD  = 4'h0;
   localparam logic [3:0] OP_ADDC = 4'h1;
   localparam logic [3:0] OP_SUBC = 4'h2;
   localparam logic [3:0] OP_SUB  = 4'h3;
   localparam logic [3:0] OP_CMP  = 4'h4;
   localparam logic [3:0] OP_DADD = 4'h5;
   localparam logic [3:0] OP_BTST = 4'h6;
   localparam logic [3:0] OP_BCLR = 4'h7;
   localparam logic [3:0] OP_BSET = 4'h8;
   localparam logic [3:0] OP_XOR  = 4'h9;
   localparam logic [3:0] OP_AND  = 4'hA;
   localparam logic [3:0] OP_MOVE = 4'hB;

   localparam int FL_V = 3;
   localparam int FL_N = 2;
   localparam int FL_Z = 1;
   localparam int FL_C = 0;

   localparam int LANE_B = 8;
endpackage

// File: rtl/alu16_binadd.sv
module alu16_binadd #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   input  logic         byte_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o,
   output logic         ovf_o
);
   import alu16_pkg::*;

   logic [W:0]      sum_w;
   logic [LANE_B:0] sum_b;
   logic            sa, sb, sr;

   assign sum_w = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
   assign sum_b = {1'b0, a_i[LANE_B-1:0]} + {1'b0, b_i[LANE_B-1:0]}
                + {{LANE_B{1'b0}}, cin_i};

   always_comb begin
      if (byte_i) begin
         sum_o  = {{(W-LANE_B){1'b0}}, sum_b[LANE_B-1:0]};
         cout_o = sum_b[LANE_B];
         sa     = a_i[LANE_B-1];
         sb     = b_i[LANE_B-1];
      end else begin
         sum_o  = sum_w[W-1:0];
         cout_o = sum_w[W];
         sa     = a_i[W-1];
         sb     = b_i[W-1];
      end
      sr    = byte_i ? sum_o[LANE_B-1] : sum_o[W-1];
      ovf_o = (sa == sb) && (sr != sa);
   end
endmodule

// File: rtl/alu16_bcdadd.sv
module alu16_bcdadd #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   input  logic         byte_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   import alu16_pkg::*;

   localparam int NDIG   = W / 4;
   localparam int BDIG   = LANE_B / 4;

   logic [NDIG:0]   dc;
   logic [W-1:0]    raw;

   assign dc[0] = cin_i;

   for (genvar g = 0; g < NDIG; g++) begin : g_digit
      logic [4:0] t;
      logic [4:0] fix;
      logic       adj;
      assign t   = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'b0, dc[g]};
      assign adj = (t > 5'd9);
      assign fix = adj ? (t + 5'd6) : t;
      assign raw[4*g +: 4] = fix[3:0];
      assign dc[g+1] = adj;
   end

   assign sum_o  = byte_i ? {{(W-LANE_B){1'b0}}, raw[LANE_B-1:0]} : raw;
   assign cout_o = byte_i ? dc[BDIG] : dc[NDIG];
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic #(
   parameter int W = 16
) (
   input  logic [W-1:0] src_i,
   input  logic [W-1:0] dst_i,
   output logic [W-1:0] and_o,
   output logic [W-1:0] clr_o,
   output logic [W-1:0] set_o,
   output logic [W-1:0] xor_o
);
   assign and_o = src_i & dst_i;
   assign clr_o = ~src_i & dst_i;
   assign set_o = src_i | dst_i;
   assign xor_o = src_i ^ dst_i;
endmodule

// File: rtl/alu16.sv
module alu16 #(
   parameter int W = 16
) (
   input  logic [W-1:0] src_i,
   input  logic [W-1:0] dst_i,
   input  logic         carry_i,
   input  logic [3:0]   op_i,
   input  logic         byte_i,
   output logic [W-1:0] result_o,
   output logic         flag_v_o,
   output logic         flag_n_o,
   output logic         flag_z_o,
   output logic         flag_c_o,
   output logic [3:0]   flag_we_o,
   output logic         result_we_o
);
   import alu16_pkg::*;

   if (W % 4 != 0) begin : g_bad_width
      $error("alu16: W must be a multiple of 4");
   end
   if (W <= LANE_B) begin : g_bad_lane
      $error("alu16: W must exceed the byte lane");
   end

   localparam logic [W-1:0] MASK_B = {{(W-LANE_B){1'b0}}, {LANE_B{1'b1}}};

   logic         is_sub;
   logic         add_cin;
   logic [W-1:0] add_b;
   logic [W-1:0] add_sum, bcd_sum;
   logic         add_cout, add_ovf, bcd_cout;
   logic [W-1:0] l_and, l_clr, l_set, l_xor;
   logic [W-1:0] lane, res;
   logic         msb, zer;
   logic [3:0]   fl;

   assign is_sub = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
   assign add_b  = is_sub ? ~src_i : src_i;

   always_comb begin
      unique case (op_i)
         OP_ADD:          add_cin = 1'b0;
         OP_SUB, OP_CMP:  add_cin = 1'b1;
         default:         add_cin = carry_i;
      endcase
   end

   alu16_binadd #(.W(W)) u_add (
      .a_i(dst_i), .b_i(add_b), .cin_i(add_cin), .byte_i(byte_i),
      .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
   );

   alu16_bcdadd #(.W(W)) u_bcd (
      .a_i(dst_i), .b_i(src_i), .cin_i(carry_i), .byte_i(byte_i),
      .sum_o(bcd_sum), .cout_o(bcd_cout)
   );

   alu16_logic #(.W(W)) u_log (
      .src_i(src_i), .dst_i(dst_i),
      .and_o(l_and), .clr_o(l_clr), .set_o(l_set), .xor_o(l_xor)
   );

   assign lane = byte_i ? MASK_B : {W{1'b1}};

   always_comb begin
      res         = dst_i;
      fl          = 4'b0000;
      flag_we_o   = 4'b0000;
      result_we_o = 1'b0;
      unique case (op_i)
         OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
            res         = add_sum;
            flag_we_o   = 4'b1111;
            result_we_o = (op_i != OP_CMP);
         end
         OP_DADD: begin
            res         = bcd_sum;
            flag_we_o   = 4'b0111;
            result_we_o = 1'b1;
         end
         OP_AND, OP_BTST: begin
            res         = l_and & lane;
            flag_we_o   = 4'b1111;
            result_we_o = (op_i == OP_AND);
         end
         OP_XOR: begin
            res         = l_xor & lane;
            flag_we_o   = 4'b1111;
            result_we_o = 1'b1;
         end
         OP_BCLR: begin res = l_clr & lane; result_we_o = 1'b1; end
         OP_BSET: begin res = l_set & lane; result_we_o = 1'b1; end
         OP_MOVE: begin res = src_i & lane; result_we_o = 1'b1; end
         default: begin res = dst_i; end
      endcase

      msb = byte_i ? res[LANE_B-1] : res[W-1];
      zer = ((res & lane) == '0);
      fl[FL_N] = msb;
      fl[FL_Z] = zer;
      unique case (op_i)
         OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
            fl[FL_V] = add_ovf;
            fl[FL_C] = add_cout;
         end
         OP_DADD: fl[FL_C] = bcd_cout;
         OP_AND, OP_BTST: fl[FL_C] = ~zer;
         OP_XOR: begin
            fl[FL_C] = ~zer;
            fl[FL_V] = byte_i ? (src_i[LANE_B-1] & dst_i[LANE_B-1])
                              : (src_i[W-1] & dst_i[W-1]);
         end
         default: ;
      endcase
      fl = fl & flag_we_o;
   end

   assign result_o = res;
   assign flag_v_o = fl[FL_V];
   assign flag_n_o = fl[FL_N];
   assign flag_z_o = fl[FL_Z];
   assign flag_c_o = fl[FL_C];
endmodule

// File: rtl/alu16_chk.sv
module alu16_chk #(
   parameter int W = 16
) (
   input logic [W-1:0] src_i,
   input logic [W-1:0] dst_i,
   input logic         carry_i,
   input logic [3:0]   op_i,
   input logic         byte_i,
   input logic [W-1:0] result_o,
   input logic         flag_v_o,
   input logic         flag_n_o,
   input logic         flag_z_o,
   input logic         flag_c_o,
   input logic [3:0]   flag_we_o,
   input logic         result_we_o
);
   import alu16_pkg::*;

   always_comb begin
      if (byte_i)
         AST_BYTE_UPPER_ZERO: assert (result_o[W-1:LANE_B] == '0 || !result_we_o); // R9
      if (op_i == OP_CMP || op_i == OP_BTST)
         AST_NO_WRITEBACK: assert (!result_we_o && flag_we_o == 4'hF); // R4
      if (op_i == OP_AND || op_i == OP_BTST || op_i == OP_XOR)
         AST_LOGIC_C_NOT_Z: assert (flag_c_o == !flag_z_o); // R6
      if (op_i == OP_AND || op_i == OP_BTST)
         AST_AND_V_CLEAR: assert (!flag_v_o); // R6
      if (op_i == OP_BCLR || op_i == OP_BSET || op_i == OP_MOVE)
         AST_FLAGS_KEPT: assert (flag_we_o == 4'h0 && result_we_o); // R8
      if (op_i == OP_DADD)
         AST_DADD_V_KEPT: assert (flag_we_o == 4'b0111 && !flag_v_o); // R5
      if (op_i >= 4'hC)
         AST_RESERVED_IDLE: assert (!result_we_o && flag_we_o == 4'h0 && result_o == dst_i); // R10
      AST_MASKED_ZERO: assert (({flag_v_o, flag_n_o, flag_z_o, flag_c_o} & ~flag_we_o) == 4'h0); // R11
   end
endmodule

bind alu16 alu16_chk #(.W(W)) u_chk (
   .src_i(src_i), .dst_i(dst_i), .carry_i(carry_i), .op_i(op_i), .byte_i(byte_i),
   .result_o(result_o), .flag_v_o(flag_v_o), .flag_n_o(flag_n_o),
   .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .flag_we_o(flag_we_o),
   .result_we_o(result_we_o)
);

// File: tb/alu16_tb.sv
module alu16_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] src, dst;
   logic        cin, bsel;
   logic [3:0]  op;
   logic [15:0] res;
   logic        fv, fn, fz, fc, rwe;
   logic [3:0]  fwe;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done  = 1'b0;

   always #2 clk = ~clk;

   alu16 u_dut (
      .src_i(src), .dst_i(dst), .carry_i(cin), .op_i(op), .byte_i(bsel),
      .result_o(res), .flag_v_o(fv), .flag_n_o(fn), .flag_z_o(fz), .flag_c_o(fc),
      .flag_we_o(fwe), .result_we_o(rwe)
   );

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic run(string tag, logic [3:0] o, logic [15:0] s, logic [15:0] d,
                      logic c, logic b, logic [15:0] er, logic [3:0] ef,
                      logic [3:0] efwe, logic erwe);
      @(negedge clk);
      op = o; src = s; dst = d; cin = c; bsel = b;
      #1;
      chk({tag, " result"}, {16'h0, res}, {16'h0, er});
      chk({tag, " flags VNZC"}, {28'h0, fv, fn, fz, fc}, {28'h0, ef});
      chk({tag, " flag_we"}, {28'h0, fwe}, {28'h0, efwe});
      chk({tag, " result_we"}, {31'h0, rwe}, {31'h0, erwe});
   endtask

   task automatic t_reset;
      @(negedge clk);
      op = 4'hB; src = '0; dst = '0; cin = 1'b0; bsel = 1'b0;
      #1;
      chk("R11 idle move result", {16'h0, res}, 32'h0);
      chk("R11 idle move flag_we", {28'h0, fwe}, 32'h0);
   endtask

   task automatic t_add;
      run("R1 R2 add overflow",   4'h0, 16'h0001, 16'h7FFF, 1'b1, 1'b0, 16'h8000, 4'b1100, 4'hF, 1'b1);
      run("R1 add carry to zero", 4'h0, 16'h0001, 16'hFFFF, 1'b0, 1'b0, 16'h0000, 4'b0011, 4'hF, 1'b1);
      run("R1 addc cin=1",        4'h1, 16'h1111, 16'h1234, 1'b1, 1'b0, 16'h2346, 4'b0000, 4'hF, 1'b1);
      run("R1 addc cin=0",        4'h1, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 16'hFFFF, 4'b0100, 4'hF, 1'b1);
   endtask

   task automatic t_add_sweep;
      logic [15:0] a = 16'hACE1, b = 16'h1D87;
      for (int i = 0; i < 40; i++) begin
         logic [16:0] ref_s;
         a = {a[14:0], a[15] ^ a[13] ^ a[12] ^ a[10]};
         b = {b[14:0], b[15] ^ b[13] ^ b[12] ^ b[10]};
         ref_s = {1'b0, a} + {1'b0, b} + {16'h0, i[0]};
         @(negedge clk);
         op = 4'h1; src = a; dst = b; cin = i[0]; bsel = 1'b0;
         #1;
         chk("R1 addc sweep", {15'h0, fc, res}, {15'h0, ref_s});
      end
   endtask

   task automatic t_sub;
      run("R3 sub no borrow",  4'h3, 16'h0003, 16'h0005, 1'b0, 1'b0, 16'h0002, 4'b0001, 4'hF, 1'b1);
      run("R3 sub borrow",     4'h3, 16'h0005, 16'h0003, 1'b1, 1'b0, 16'hFFFE, 4'b0100, 4'hF, 1'b1);
      run("R2 R3 sub overflow",4'h3, 16'h0001, 16'h8000, 1'b0, 1'b0, 16'h7FFF, 4'b1001, 4'hF, 1'b1);
      run("R3 subc c=0",       4'h2, 16'h0003, 16'h0005, 1'b0, 1'b0, 16'h0001, 4'b0001, 4'hF, 1'b1);
      run("R3 subc c=1",       4'h2, 16'h0003, 16'h0005, 1'b1, 1'b0, 16'h0002, 4'b0001, 4'hF, 1'b1);
   endtask

   task automatic t_cmp;
      run("R4 cmp equal",  4'h4, 16'h0003, 16'h0003, 1'b0, 1'b0, 16'h0000, 4'b0011, 4'hF, 1'b0);
      run("R4 cmp less",   4'h4, 16'h0005, 16'h0003, 1'b0, 1'b0, 16'hFFFE, 4'b0100, 4'hF, 1'b0);
   endtask

   task automatic t_dadd;
      run("R5 dadd digit carry", 4'h5, 16'h0001, 16'h1999, 1'b0, 1'b0, 16'h2000, 4'b0000, 4'b0111, 1'b1);
      run("R5 dadd wrap 9999",   4'h5, 16'h0001, 16'h9999, 1'b0, 1'b0, 16'h0000, 4'b0011, 4'b0111, 1'b1);
      run("R5 dadd with cin",    4'h5, 16'h0037, 16'h0045, 1'b1, 1'b0, 16'h0083, 4'b0000, 4'b0111, 1'b1);
      run("R5 R9 dadd byte N",   4'h5, 16'h0037, 16'h5545, 1'b1, 1'b1, 16'h0083, 4'b0100, 4'b0111, 1'b1);
      run("R5 R9 dadd byte 99",  4'h5, 16'h3401, 16'h1299, 1'b0, 1'b1, 16'h0000, 4'b0011, 4'b0111, 1'b1);
   endtask

   task automatic t_logic;
      run("R6 and nonzero", 4'hA, 16'hF0F0, 16'h0FF0, 1'b0, 1'b0, 16'h00F0, 4'b0001, 4'hF, 1'b1);
      run("R6 and zero",    4'hA, 16'h00FF, 16'hFF00, 1'b1, 1'b0, 16'h0000, 4'b0010, 4'hF, 1'b1);
      run("R6 bit test",    4'h6, 16'h8000, 16'h8001, 1'b0, 1'b0, 16'h8000, 4'b0101, 4'hF, 1'b0);
      run("R7 xor both neg",4'h9, 16'h8001, 16'h8003, 1'b0, 1'b0, 16'h0002, 4'b1001, 4'hF, 1'b1);
      run("R7 xor one neg", 4'h9, 16'h0001, 16'h8000, 1'b0, 1'b0, 16'h8001, 4'b0101, 4'hF, 1'b1);
   endtask

   task automatic t_noflag;
      run("R8 bit clear", 4'h7, 16'h00FF, 16'h1234, 1'b1, 1'b0, 16'h1200, 4'b0000, 4'h0, 1'b1);
      run("R8 bit set",   4'h8, 16'h000F, 16'h1230, 1'b1, 1'b0, 16'h123F, 4'b0000, 4'h0, 1'b1);
      run("R8 move",      4'hB, 16'hBEEF, 16'h0000, 1'b1, 1'b0, 16'hBEEF, 4'b0000, 4'h0, 1'b1);
   endtask

   task automatic t_byte;
      run("R9 byte add ovf",  4'h0, 16'h0001, 16'hAA7F, 1'b0, 1'b1, 16'h0080, 4'b1100, 4'hF, 1'b1);
      run("R9 byte add wrap", 4'h0, 16'h0001, 16'h12FF, 1'b0, 1'b1, 16'h0000, 4'b0011, 4'hF, 1'b1);
      run("R9 byte sub",      4'h3, 16'h0001, 16'h0000, 1'b0, 1'b1, 16'h00FF, 4'b0100, 4'hF, 1'b1);
      run("R9 byte move",     4'hB, 16'hBEEF, 16'h0000, 1'b0, 1'b1, 16'h00EF, 4'b0000, 4'h0, 1'b1);
   endtask

   task automatic t_reserved;
      run("R10 code C", 4'hC, 16'h1111, 16'h2222, 1'b1, 1'b0, 16'h2222, 4'b0000, 4'h0, 1'b0);
      run("R10 code F", 4'hF, 16'hFFFF, 16'h8000, 1'b1, 1'b1, 16'h8000, 4'b0000, 4'h0, 1'b0);
   endtask

   initial begin
      op = 4'hB; src = '0; dst = '0; cin = 1'b0; bsel = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_reset();
      t_add();
      t_add_sweep();
      t_sub();
      t_cmp();
      t_dadd();
      t_logic();
      t_noflag();
      t_byte();
      t_reserved();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule